// File: doc/BRIEF.md
# Multichannel Conversion Sequencer

This block decides which of eight analog inputs the converter samples in each frame. A control-register write hands it a channel-enable mask and a repeat flag. Every conversion-start strobe (the chip-select falling edge of a frame) starts a conversion of the channel the multiplexer currently selects. The block reports that conversion one cycle later as a valid pulse with a 4-bit channel tag. Later in the same frame an advance strobe (the 14th serial-clock falling edge) moves the multiplexer select to the next enabled channel. The select only ever moves up in channel number.

The repeat flag picks one of two modes. In one-shot mode the block goes idle after the highest enabled channel. In repeat mode it wraps back to the lowest enabled channel and keeps cycling. While idle, every conversion is reported with an all-ones tag. Every register write restarts the sequence at the lowest enabled channel, even when the mask is the same as before. The analog multiplexer, the conversion itself and the serial shifter are outside this block.

Top module: `conv_seq`

## Requirements
- R1: After a synchronous reset, `seq_idle` is 1, `conv_valid` is 0 and `mux_sel` is 0.
- R2: A write (`cfg_wr` high) loads the mask and repeat flag. From the next cycle, `mux_sel` is the lowest set bit of the mask. `seq_idle` is 1 exactly when the mask is all zeros.
- R3: A `conv_start` pulse gives `conv_valid` high for exactly the next cycle. If the block was not idle, `conv_tag` is then {1'b0, mux_sel as it was at the start}.
- R4: An `sel_adv` pulse after a conversion moves `mux_sel` to the lowest enabled channel above the current one. With no write and no advance, `mux_sel` holds its value.
- R5: In one-shot mode (repeat = 0), an advance from the highest enabled channel sets `seq_idle`. The block stays idle through any number of starts and advances until the next write.
- R6: In repeat mode (repeat = 1), an advance from the highest enabled channel returns `mux_sel` to the lowest enabled channel. The block never goes idle while the mask is non-zero.
- R7: A conversion started while idle, including when the mask is empty, is reported with `conv_tag` = 4'b1111.
- R8: A write restarts the sequence at the lowest enabled channel, even when the mask is unchanged. If a write and an advance fall in the same cycle, the write wins.
- R9: An `sel_adv` pulse with no conversion started since the last advance or write leaves `mux_sel` and `seq_idle` unchanged.
- R10: Every tag for a real channel is the binary channel number 0 to 7, with its most significant bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Accepted control-register write strobe |
| cfg_mask | input | 8 | Channel-enable mask; bit i enables channel i |
| cfg_repeat | input | 1 | 1 = wrap-around mode, 0 = one-shot mode |
| conv_start | input | 1 | Conversion-start strobe (frame begins) |
| sel_adv | input | 1 | Select-advance strobe (14th serial-clock falling edge) |
| mux_sel | output | 3 | Channel the multiplexer presents to the converter |
| seq_idle | output | 1 | One-shot sequence finished, or mask empty |
| conv_valid | output | 1 | One-cycle pulse reporting a started conversion |
| conv_tag | output | 4 | Channel tag of the reported conversion; 4'b1111 when idle |

## Verification
The bench steps through all 256 masks in both modes and compares each reported tag and each select move with an arithmetic model of ascending order, wrapping and going idle. Two functions can fall in the same cycle: a register write and an advance of the select. The bench provokes this by issuing the advance in the same cycle as a restart write that carries the unchanged mask. It judges the result by checking that the select is back at the lowest enabled channel and not one step past it. It also checks a write issued in the middle of a sequence, and a start issued in the same cycle as a write, which must report the channel selected before the write.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
    localparam int NUM_CH = 8;
    localparam int IDX_W  = $clog2(NUM_CH);
    localparam int TAG_W  = 4;

    typedef struct packed {
        logic [NUM_CH-1:0] mask;
        logic              rpt;
        logic [IDX_W-1:0]  cur;
        logic              idle;
        logic              pend;
        logic              cv;
        logic [TAG_W-1:0]  tag;
    } seq_state_t;
endpackage

// File: rtl/seq_pick.sv
module seq_pick #(
    parameter int NCH  = 8,
    parameter int IDXW = $clog2(NCH)
) (
    input  logic [NCH-1:0]  mask,
    input  logic [IDXW-1:0] cur,
    output logic            above_found,
    output logic [IDXW-1:0] above_idx,
    output logic            low_found,
    output logic [IDXW-1:0] low_idx
);
    logic [NCH-1:0] upper;

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_upper
            assign upper[gi] = mask[gi] && (gi > int'(cur));
        end
    endgenerate

    always_comb begin
        above_found = 1'b0;
        above_idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (upper[i]) begin
                above_found = 1'b1;
                above_idx   = IDXW'(i);
            end
        end
    end

    always_comb begin
        low_found = 1'b0;
        low_idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i]) begin
                low_found = 1'b1;
                low_idx   = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/seq_tag_fmt.sv
module seq_tag_fmt #(
    parameter int IDXW = 3,
    parameter int TAGW = 4
) (
    input  logic            idle,
    input  logic [IDXW-1:0] cur,
    output logic [TAGW-1:0] tag
);
    localparam int PADW = TAGW - IDXW;

    always_comb begin
        if (idle) tag = '1;
        else      tag = {{PADW{1'b0}}, cur};
    end
endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import conv_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [NUM_CH-1:0] cfg_mask,
    input  logic              cfg_repeat,
    input  logic              conv_start,
    input  logic              sel_adv,
    output logic [IDX_W-1:0]  mux_sel,
    output logic              seq_idle,
    output logic              conv_valid,
    output logic [TAG_W-1:0]  conv_tag
);
    seq_state_t st_q, st_d;

    logic             adv_found, adv_lfound, wr_found, wr_hfound;
    logic [IDX_W-1:0] adv_idx, adv_low, wr_low, wr_hidx;
    logic [TAG_W-1:0] tag_w;

    // search over the live mask from the current select
    seq_pick #(.NCH(NUM_CH), .IDXW(IDX_W)) u_pick_live (
        .mask(st_q.mask), .cur(st_q.cur),
        .above_found(adv_found), .above_idx(adv_idx),
        .low_found(adv_lfound), .low_idx(adv_low)
    );

    // lowest channel of an incoming write
    seq_pick #(.NCH(NUM_CH), .IDXW(IDX_W)) u_pick_wr (
        .mask(cfg_mask), .cur(st_q.cur),
        .above_found(wr_hfound), .above_idx(wr_hidx),
        .low_found(wr_found), .low_idx(wr_low)
    );

    seq_tag_fmt #(.IDXW(IDX_W), .TAGW(TAG_W)) u_tag (
        .idle(st_q.idle), .cur(st_q.cur), .tag(tag_w)
    );

    always_comb begin
        st_d    = st_q;
        st_d.cv = 1'b0;

        // advance the select once a conversion is in flight
        if (sel_adv && st_q.pend) begin
            st_d.pend = 1'b0;
            if (adv_found)                    st_d.cur  = adv_idx;
            else if (st_q.rpt && adv_lfound)  st_d.cur  = adv_low;
            else                              st_d.idle = 1'b1;
        end

        // report the conversion of the channel selected at the start
        if (conv_start) begin
            st_d.cv   = 1'b1;
            st_d.tag  = tag_w;
            st_d.pend = !st_q.idle;
        end

        // a write restarts everything and wins over an advance
        if (cfg_wr) begin
            st_d.mask = cfg_mask;
            st_d.rpt  = cfg_repeat;
            st_d.cur  = wr_low;
            st_d.idle = !wr_found;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.idle <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mux_sel    = st_q.cur;
    assign seq_idle   = st_q.idle;
    assign conv_valid = st_q.cv;
    assign conv_tag   = st_q.tag;
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk
    import conv_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr,
    input logic [NUM_CH-1:0] cfg_mask,
    input logic              conv_start,
    input logic              sel_adv,
    input logic [IDX_W-1:0]  mux_sel,
    input logic              seq_idle,
    input logic              conv_valid,
    input logic [TAG_W-1:0]  conv_tag
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (seq_idle && !conv_valid && mux_sel == '0));

    assert_write_low0_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_mask[0]) |=> (mux_sel == '0 && !seq_idle));

    assert_write_empty_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_mask == '0) |=> seq_idle);

    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> conv_valid);

    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
        !conv_start |=> !conv_valid);

    assert_hold_sel_R4: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wr && !sel_adv) |=> $stable(mux_sel));

    assert_idle_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (seq_idle && !cfg_wr) |=> seq_idle);

    assert_idle_tag_R7: assert property (@(posedge clk) disable iff (rst)
        (conv_start && seq_idle) |=> (conv_tag == '1));

    assert_tag_msb_R10: assert property (@(posedge clk) disable iff (rst)
        (conv_valid && conv_tag != '1) |-> (conv_tag[TAG_W-1] == 1'b0));
endmodule

bind conv_seq conv_seq_chk u_chk (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_mask(cfg_mask),
    .conv_start(conv_start), .sel_adv(sel_adv), .mux_sel(mux_sel),
    .seq_idle(seq_idle), .conv_valid(conv_valid), .conv_tag(conv_tag)
);

// File: tb/conv_seq_test.sv
module conv_seq_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_mask = '0;
    logic       cfg_repeat = 1'b0;
    logic       conv_start = 1'b0;
    logic       sel_adv = 1'b0;
    logic [2:0] mux_sel;
    logic       seq_idle;
    logic       conv_valid;
    logic [3:0] conv_tag;

    int total = 0;
    int bad = 0;

    // model state
    logic [7:0] m_mask;
    logic       m_rpt;
    logic [2:0] m_cur;
    logic       m_idle;
    logic       m_pend;

    always #2 clk = ~clk;

    conv_seq uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_mask(cfg_mask),
        .cfg_repeat(cfg_repeat), .conv_start(conv_start), .sel_adv(sel_adv),
        .mux_sel(mux_sel), .seq_idle(seq_idle), .conv_valid(conv_valid),
        .conv_tag(conv_tag)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lowest(input logic [7:0] m);
        for (int i = 0; i < 8; i++) if (m[i]) return i;
        return 0;
    endfunction

    function automatic int above(input logic [7:0] m, input int c);
        for (int i = c + 1; i < 8; i++) if (m[i]) return i;
        return -1;
    endfunction

    task automatic model_write(input logic [7:0] m, input logic r);
        m_mask = m; m_rpt = r; m_cur = 3'(lowest(m));
        m_idle = (m == 0); m_pend = 1'b0;
    endtask

    task automatic model_adv();
        int n;
        if (m_pend) begin
            m_pend = 1'b0;
            n = above(m_mask, int'(m_cur));
            if (n >= 0) m_cur = 3'(n);
            else if (m_rpt) m_cur = 3'(lowest(m_mask));
            else m_idle = 1'b1;
        end
    endtask

    task automatic do_write(input logic [7:0] m, input logic r, input logic with_adv);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_mask = m; cfg_repeat = r; sel_adv = with_adv;
        @(negedge clk);
        cfg_wr = 1'b0; sel_adv = 1'b0;
        model_write(m, r);
        check("R2 sel after write", int'(mux_sel), int'(m_cur));
        check("R2 idle after write", int'(seq_idle), int'(m_idle));
    endtask

    task automatic do_start();
        int exp_tag;
        exp_tag = m_idle ? 15 : int'(m_cur);
        @(negedge clk);
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        check("R3 valid pulse", int'(conv_valid), 1);
        check(m_idle ? "R7 idle tag" : "R3 tag", int'(conv_tag), exp_tag);
        if (!m_idle) check("R10 tag msb", int'(conv_tag[3]), 0);
        m_pend = !m_idle;
        @(negedge clk);
        check("R3 single pulse", int'(conv_valid), 0);
    endtask

    task automatic do_adv(input string req);
        @(negedge clk);
        sel_adv = 1'b1;
        @(negedge clk);
        sel_adv = 1'b0;
        model_adv();
        check(req, int'(mux_sel), int'(m_cur));
        check(req, int'(seq_idle), int'(m_idle));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle", int'(seq_idle), 1);
        check("R1 valid", int'(conv_valid), 0);
        check("R1 sel", int'(mux_sel), 0);
        model_write(8'h00, 1'b0);

        // R7: start with empty mask after reset
        do_start();

        // R9: advance without a conversion is ignored
        do_write(8'b0110_1000, 1'b0, 1'b0);
        do_adv("R9 adv ignored");

        // full sweep of masks and modes
        for (int r = 0; r < 2; r++) begin
            for (int m = 0; m < 256; m++) begin
                int steps;
                steps = $countones(8'(m)) * (r + 1) + 2;
                do_write(8'(m), r[0], 1'b0);
                for (int s = 0; s < steps; s++) begin
                    do_start();
                    do_adv(r ? "R6 wrap step" : "R5 one-shot step");
                end
                // R8: restart mid-sequence, same mask, colliding with an advance
                if ($countones(8'(m)) > 1) begin
                    do_start();
                    do_write(8'(m), r[0], 1'b1);
                    check("R8 restart low", int'(mux_sel), lowest(8'(m)));
                    do_adv("R9 adv after restart");
                end
            end
        end

        // R4: stable select with no strobes
        do_write(8'b1010_0100, 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        check("R4 hold", int'(mux_sel), 2);

        // start in the same cycle as a write reports the old selection
        @(negedge clk);
        conv_start = 1'b1; cfg_wr = 1'b1; cfg_mask = 8'b0001_0000; cfg_repeat = 1'b0;
        @(negedge clk);
        conv_start = 1'b0; cfg_wr = 1'b0;
        check("R3 start with write", int'(conv_tag), 2);
        check("R8 write with start", int'(mux_sel), 4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule